// File: doc/BRIEF.md
# Dual-Style Multiplexed Host Bus Register Slave

This block connects a small host controller to a block of camera-control registers over a single 8-bit bus. The bus carries the register address first and the data after it. A strap input selects one of two host bus styles. In the first style, a read/write level is qualified by a data strobe. In the second style, separate active-low read and write enables are used. In both styles the address is captured while chip select is low and the address strobe is high. The block then decodes that address to a status register, a command register, a bank of control registers and a measurement readout port.

Measurement results are 16 bits wide. They live in an external RAM that the block addresses through a pointer. The host loads the pointer once. It then reads the high byte and the low byte of each result in turn. Every completed low-byte read steps the pointer, so a block of results can be read with no further pointer writes. Each read holds the active-low wait line low for a fixed number of clocks before the data is driven. Writes never hold the wait line low.

All host inputs are sampled on the rising edge of `clk`. The interface assumes the host signals are already synchronous to that clock.

Top module: `mcu_mux_bus_slave`

## Requirements
- R1: On a rising clock edge where `cs_n` is low and `ale` is high, `ad_in` is captured as the register address. An `ale` pulse while `cs_n` is high leaves the captured address unchanged.
- R2: With `style_sel`=1, a read is `ds_n` low with `rw` high, and a write is `ds_n` low with `rw` low. In this style `rd_n` and `wr_n` are ignored. With `style_sel`=0, a read is `rd_n` low, and a write is `wr_n` low with `rd_n` high. In this style `ds_n` and `rw` are ignored. Any strobe seen while `cs_n` is high has no effect.
- R3: Address 0x00 is the read-only status register. Bit 0 is `busy_in`, bit 1 is `hiband_in` (1 = Hi-band mode), bit 2 is `pal_in` (1 = PAL, 0 = NTSC), and bits 7:3 read 0. Reading it changes no state.
- R4: Addresses 0x10 to 0x17 are eight read/write control registers, and all reset to 0x00. Register k appears on `ctrl_regs[8k+7:8k]`.
- R5: The first clock that sees an active read strobe starts a wait. `wait_n` is low for exactly 2 cycles. In the cycle `wait_n` returns high, `ad_oe` goes high with the read data on `ad_out`. The data stays driven until the cycle after the strobe is released.
- R6: A write never drives `wait_n` low. The data is stored on the first clock that sees the write strobe.
- R7: Address 0x01 is the read/write measurement pointer, and it resets to 0x00. Its value drives `meas_addr`.
- R8: A read of address 0x02 returns `meas_data[15:8]` and leaves the pointer unchanged. A read of address 0x03 returns `meas_data[7:0]` and then adds one to the pointer, wrapping from 0xFF to 0x00.
- R9: Address 0x04 is the command register. Bit 0 drives `meas_peak` (1 = peak-hold data, 0 = integration data). Bit 1 drives `meas_page`, which selects one of two RAM pages. Bits 7:2 read 0, and the register resets to 0.
- R10: A write to any address not named above, or to the read-only addresses 0x00, 0x02 and 0x03, changes no state. A read from an unnamed address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| style_sel | input | 1 | Bus style strap: 1 = R/W level plus data strobe, 0 = separate enables |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address strobe, active high |
| rw | input | 1 | Read/write level for style 1 (1 = read) |
| ds_n | input | 1 | Data strobe for style 1, active low |
| rd_n | input | 1 | Read enable for style 0, active low |
| wr_n | input | 1 | Write enable for style 0, active low |
| ad_in | input | 8 | Multiplexed address/data from the host |
| ad_out | output | 8 | Read data to the host |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| wait_n | output | 1 | Wait to the host, active low |
| busy_in | input | 1 | Overlay engine busy flag |
| hiband_in | input | 1 | Hi-band mode flag |
| pal_in | input | 1 | PAL mode flag |
| meas_addr | output | 8 | Measurement RAM word address (pointer) |
| meas_page | output | 1 | Measurement RAM page select |
| meas_peak | output | 1 | Peak-hold (1) or integration (0) data select |
| meas_data | input | 16 | Measurement word read combinationally at `meas_addr` |
| ctrl_regs | output | 64 | Control register bank, register k at bits 8k+7:8k |

## Verification
The assertions assume four things about the host. It holds a read strobe until it has seen `wait_n` return high and taken the data. It never asserts a read and a write in the same cycle. It keeps `ale` apart from the strobes. All of its inputs are synchronous to `clk`. The bench meets these conditions by changing inputs only on falling edges and holding each strobe for the full wait-plus-data window. It also separates the address phase from the strobe phase by one clock. The stimulus for the ignored-strobe cases (deselected chip, the other style's pins) still respects these limits.

// File: rtl/mcu_mux_bus_slave.sv
module mcu_mux_bus_slave #(
  parameter int          NCTRL     = 8,
  parameter logic [7:0]  CTRL_BASE = 8'h10,
  parameter int          PTR_W     = 8,
  parameter int          WAIT_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               style_sel,
  input  logic               cs_n,
  input  logic               ale,
  input  logic               rw,
  input  logic               ds_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic [7:0]         ad_in,
  output logic [7:0]         ad_out,
  output logic               ad_oe,
  output logic               wait_n,
  input  logic               busy_in,
  input  logic               hiband_in,
  input  logic               pal_in,
  output logic [PTR_W-1:0]   meas_addr,
  output logic               meas_page,
  output logic               meas_peak,
  input  logic [15:0]        meas_data,
  output logic [NCTRL*8-1:0] ctrl_regs
);
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam int IW = (NCTRL > 1) ? $clog2(NCTRL) : 1;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_PTR  = 8'h01;
  localparam logic [7:0] A_DHI  = 8'h02;
  localparam logic [7:0] A_DLO  = 8'h03;
  localparam logic [7:0] A_CMD  = 8'h04;

  logic             sel, rd_act, wr_act, rd_q, wr_q, rd_start, wr_start;
  logic [7:0]       addr_q, rdata_q, rd_mux;
  logic [CW-1:0]    cnt_q;
  logic             oe_q;
  logic [PTR_W-1:0] ptr_q;
  logic [1:0]       cmd_q;
  logic [NCTRL*8-1:0] ctrl_q;
  logic [8:0]       ctrl_off;
  logic             ctrl_hit;
  logic [IW-1:0]    ctrl_idx;

  assign sel    = !cs_n;
  assign rd_act = sel && (style_sel ? (!ds_n && rw)  : !rd_n);
  assign wr_act = sel && (style_sel ? (!ds_n && !rw) : (!wr_n && rd_n));
  assign rd_start = rd_act && !rd_q;
  assign wr_start = wr_act && !wr_q;

  assign ctrl_off = {1'b0, addr_q} - {1'b0, CTRL_BASE};
  assign ctrl_hit = (addr_q >= CTRL_BASE) && (ctrl_off < 9'(NCTRL));
  assign ctrl_idx = ctrl_off[IW-1:0];

  always_comb begin
    rd_mux = 8'h00;
    case (addr_q)
      A_STAT:  rd_mux = {5'b0, pal_in, hiband_in, busy_in};
      A_PTR:   rd_mux = 8'(ptr_q);
      A_DHI:   rd_mux = meas_data[15:8];
      A_DLO:   rd_mux = meas_data[7:0];
      A_CMD:   rd_mux = {6'b0, cmd_q};
      default: if (ctrl_hit) rd_mux = ctrl_q[ctrl_idx*8 +: 8];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
      rdata_q <= '0;
      ptr_q   <= '0;
      cmd_q   <= '0;
    end else begin
      rd_q <= rd_act;
      wr_q <= wr_act;
      if (sel && ale) addr_q <= ad_in;
      if (!rd_act) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else if (rd_start) begin
        cnt_q <= CW'(WAIT_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          rdata_q <= rd_mux;
          oe_q    <= 1'b1;
          if (addr_q == A_DLO) ptr_q <= ptr_q + 1'b1;
        end
      end
      if (wr_start) begin
        if (addr_q == A_PTR) ptr_q <= ad_in[PTR_W-1:0];
        if (addr_q == A_CMD) cmd_q <= ad_in[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_start && ctrl_hit)
      for (int k = 0; k < NCTRL; k++)
        if (ctrl_idx == IW'(k)) ctrl_q[k*8 +: 8] <= ad_in;
  end

  assign wait_n    = (cnt_q == '0);
  assign ad_oe     = oe_q;
  assign ad_out    = rdata_q;
  assign meas_addr = ptr_q;
  assign meas_peak = cmd_q[0];
  assign meas_page = cmd_q[1];
  assign ctrl_regs = ctrl_q;
endmodule

// File: rtl/mcu_mux_bus_slave_chk.sv
module mcu_mux_bus_slave_chk #(
  parameter int PTR_W    = 8,
  parameter int WAIT_CYC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             style_sel,
  input logic             cs_n,
  input logic             rw,
  input logic             ds_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic             wait_n,
  input logic             ad_oe,
  input logic [PTR_W-1:0] meas_addr
);
  logic       rd_seen, wr_seen;
  logic [7:0] low_run;

  assign rd_seen = !cs_n && (style_sel ? (!ds_n && rw)  : !rd_n);
  assign wr_seen = !cs_n && (style_sel ? (!ds_n && !rw) : (!wr_n && rd_n));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_run <= '0;
    else if (!wait_n) low_run <= (low_run == 8'hFF) ? low_run : low_run + 1'b1;
    else low_run <= '0;
  end

  a_r5_wait_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_n) |-> (low_run == 8'(WAIT_CYC)));

  a_r5_oe_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> $past(rd_seen));

  a_r5_oe_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> wait_n);

  a_r6_write_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    wr_seen |=> wait_n);

  a_r2_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> (wait_n && !ad_oe));

  a_r8_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_addr) |-> ((meas_addr == PTR_W'($past(meas_addr) + 1'b1)) || $past(wr_seen)));
endmodule

bind mcu_mux_bus_slave mcu_mux_bus_slave_chk #(.PTR_W(PTR_W), .WAIT_CYC(WAIT_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .cs_n(cs_n), .rw(rw), .ds_n(ds_n),
  .rd_n(rd_n), .wr_n(wr_n), .wait_n(wait_n), .ad_oe(ad_oe), .meas_addr(meas_addr)
);

// File: tb/mcu_mux_bus_slave_tb_top.sv
`timescale 1ns/1ps
module mcu_mux_bus_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic style_sel = 1'b0, cs_n = 1'b1, ale = 1'b0, rw = 1'b1, ds_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic ad_oe, wait_n;
  logic busy_in = 1'b0, hiband_in = 1'b0, pal_in = 1'b0;
  logic [7:0] meas_addr;
  logic meas_page, meas_peak;
  logic [15:0] meas_data;
  logic [63:0] ctrl_regs;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_ptr;
  logic [7:0] exp_ctrl [8];
  logic [1:0] exp_cmd;

  always #2 clk = ~clk;

  function automatic logic [15:0] meas_val(input logic [7:0] a, input logic pg, input logic pk);
    return {a ^ {pg, pk, 6'h2A}, (~a) + {pg, pk, 6'h05}};
  endfunction
  assign meas_data = meas_val(meas_addr, meas_page, meas_peak);

  mcu_mux_bus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .style_sel(style_sel), .cs_n(cs_n), .ale(ale), .rw(rw),
    .ds_n(ds_n), .rd_n(rd_n), .wr_n(wr_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .wait_n(wait_n), .busy_in(busy_in), .hiband_in(hiband_in), .pal_in(pal_in),
    .meas_addr(meas_addr), .meas_page(meas_page), .meas_peak(meas_peak),
    .meas_data(meas_data), .ctrl_regs(ctrl_regs)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [7:0] a);
    @(negedge clk); cs_n = 1'b0; ad_in = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
  endtask

  task automatic strobe(input logic is_rd, input logic on);
    if (style_sel) begin rw = is_rd; ds_n = !on; end
    else if (is_rd) rd_n = !on;
    else wr_n = !on;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    logic w1, w2;
    addr_phase(a);
    ad_in = d; strobe(1'b0, 1'b1);
    @(negedge clk); w1 = wait_n;
    @(negedge clk); w2 = wait_n;
    strobe(1'b0, 1'b0); cs_n = 1'b1; rw = 1'b1;
    chk("R6 wait_n during write", {w1, w2}, 2'b11);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    logic w1, w2, w3, oe;
    addr_phase(a);
    strobe(1'b1, 1'b1);
    @(negedge clk); w1 = wait_n;
    @(negedge clk); w2 = wait_n;
    @(negedge clk); w3 = wait_n; oe = ad_oe; d = ad_out;
    strobe(1'b1, 1'b0); cs_n = 1'b1;
    @(negedge clk);
    chk("R5 wait pattern and drive", {w1, w2, w3, oe, ad_oe}, 5'b00110);
  endtask

  task automatic check_ctrl(input string tag);
    for (int k = 0; k < 8; k++) chk(tag, ctrl_regs[k*8 +: 8], exp_ctrl[k]);
  endtask

  task automatic run_style(input logic s);
    logic [7:0] d;
    style_sel = s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_ptr = 8'h00; exp_cmd = 2'b00;
    for (int k = 0; k < 8; k++) exp_ctrl[k] = 8'h00;
    chk("R7 reset pointer", meas_addr, 8'h00);
    chk("R9 reset command", {meas_page, meas_peak}, 2'b00);
    chk("R5 reset idle", {wait_n, ad_oe}, 2'b10);
    check_ctrl("R4 reset control");

    for (int v = 0; v < 8; v++) begin
      {pal_in, hiband_in, busy_in} = 3'(v);
      bus_read(8'h00, d);
      chk("R3 status bits", d, 32'(v));
    end
    chk("R3 status read leaves pointer", meas_addr, exp_ptr);

    for (int k = 0; k < 8; k++) begin
      exp_ctrl[k] = 8'(k * 37 + 11 + s * 100);
      bus_write(8'h10 + 8'(k), exp_ctrl[k]);
    end
    check_ctrl("R4 control port");
    for (int k = 0; k < 8; k++) begin
      bus_read(8'h10 + 8'(k), d);
      chk("R4 control readback", d, exp_ctrl[k]);
    end

    addr_phase(8'h10);
    cs_n = 1'b1; ad_in = 8'h11; ale = 1'b1;
    @(negedge clk); ale = 1'b0; cs_n = 1'b0; ad_in = 8'h77; strobe(1'b0, 1'b1);
    @(negedge clk); strobe(1'b0, 1'b0); cs_n = 1'b1; rw = 1'b1;
    exp_ctrl[0] = 8'h77;
    check_ctrl("R1 ale ignored when deselected");

    addr_phase(8'h12);
    cs_n = 1'b1; ad_in = 8'h99; strobe(1'b0, 1'b1);
    @(negedge clk); chk("R2 deselected write no wait", wait_n, 1'b1);
    @(negedge clk); strobe(1'b0, 1'b0); rw = 1'b1; strobe(1'b1, 1'b1);
    @(negedge clk); @(negedge clk);
    chk("R2 deselected read idle", {wait_n, ad_oe}, 2'b10);
    strobe(1'b1, 1'b0);
    check_ctrl("R2 deselected write ignored");

    addr_phase(8'h13);
    ad_in = 8'h5C;
    if (s) wr_n = 1'b0; else begin rw = 1'b0; ds_n = 1'b0; end
    @(negedge clk); @(negedge clk);
    chk("R2 other style pins ignored", {wait_n, ad_oe}, 2'b10);
    wr_n = 1'b1; ds_n = 1'b1; rw = 1'b1; cs_n = 1'b1;
    check_ctrl("R2 other style write ignored");

    for (int c = 0; c < 4; c++) begin
      exp_cmd = 2'(c);
      bus_write(8'h04, {6'h2D, exp_cmd});
      chk("R9 command outputs", {meas_page, meas_peak}, exp_cmd);
      bus_read(8'h04, d);
      chk("R9 command readback", d, {6'b0, exp_cmd});
      exp_ptr = 8'hFC - 8'(c * 16);
      bus_write(8'h01, exp_ptr);
      chk("R7 pointer port", meas_addr, exp_ptr);
      bus_read(8'h01, d);
      chk("R7 pointer readback", d, exp_ptr);
      for (int i = 0; i < 6; i++) begin
        logic [15:0] ev;
        ev = meas_val(exp_ptr, exp_cmd[1], exp_cmd[0]);
        bus_read(8'h02, d);
        chk("R8 high byte", d, ev[15:8]);
        chk("R8 high byte keeps pointer", meas_addr, exp_ptr);
        bus_read(8'h03, d);
        chk("R8 low byte", d, ev[7:0]);
        exp_ptr = exp_ptr + 8'h01;
        chk("R8 pointer advance", meas_addr, exp_ptr);
      end
    end

    for (int a = 0; a < 256; a += 7) begin
      logic [7:0] aa;
      aa = 8'(a);
      if (aa > 8'h04 && !(aa >= 8'h10 && aa <= 8'h17)) begin
        bus_write(aa, 8'hEE);
        bus_read(aa, d);
        chk("R10 undefined reads zero", d, 8'h00);
      end
    end
    check_ctrl("R10 undefined writes ignored");
    bus_write(8'h02, 8'h33);
    bus_write(8'h03, 8'h34);
    bus_write(8'h00, 8'h35);
    chk("R10 read-only writes keep pointer", meas_addr, exp_ptr);
    chk("R10 read-only writes keep command", {meas_page, meas_peak}, exp_cmd);
    {pal_in, hiband_in, busy_in} = 3'b000;
    bus_read(8'h00, d);
    chk("R10 status unchanged by write", d, 8'h00);
  endtask

  initial begin
    run_style(1'b1);
    run_style(1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule